// File: doc/BRIEF.md
# Capture/Compare General-Purpose Timer

This block is a free-running up-counter with two edge-triggered input capture channels and three output compare channels. The counter advances from either an internal tick or rising edges of an external clock pin. A programmable prescaler divides whichever source is selected. Each capture channel copies the counter into its own register when its pin shows the chosen edge. Each compare channel watches for the counter reaching its programmed value and then acts on its output pin.

Software sets up and reads the block through a simple word-wide register port. Writes take effect at the clock edge, and reads are combinational on the address. Every capture and compare event raises a sticky flag. One interrupt line reports any flag whose enable bit is set. Software can also trigger a compare action directly, without waiting for a counter match.

Register addresses: 0 control, 1 prescaler, 2 status flags, 3 interrupt enables, 4 force compare (write-only, reads 0), 5 counter (read-only), 6 and 7 capture channels 0 and 1 (read-only), 8 to 10 compare values 0 to 2.

Control word layout:
- bit 0 enables counting.
- bit 1 selects the source: 0 is the internal tick, 1 is the external clock.
- bits [3:2] and [5:4] set the edge for capture channels 0 and 1.
- bits [8:6], [11:9] and [14:12] set the output mode for compare channels 0, 1 and 2.

Status and enable bit layout: bits 0 and 1 belong to capture channels 0 and 1, and bits 2 to 4 belong to compare channels 0 to 2.

Top module: `capcmp_timer`

## Requirements
- R1: After reset, the counter, all status flags, the irq output and all compare outputs are 0.
- R2: While enabled, the counter rises by exactly 1 for every P+1 pulses of the selected source, where P is the 12-bit prescaler value. While disabled, the counter holds its value.
- R3: With control bit 1 set, the counter advances on rising edges of extClk, after a two-flop synchronizer, and ignores tick.
- R4: The capture edge code is 0 for off, 1 for rising, 2 for falling and 3 for both. On a matching edge of its pin, a channel loads the current counter value into its capture register and sets its status flag.
- R5: When the counter steps to a value equal to a channel's compare value, that channel sets its status flag (bit 2+j) and performs its output action in the same cycle.
- R6: The output mode codes are 0 for no change, 1 for toggle, 2 for clear and 3 for set.
- R7: Mode 4 gives a low pulse. A compare event drives the pin to 0. Any later counter step without an event drives it to 1.
- R8: Writing 1 to bit j of the force register performs channel j's output action at once and leaves its status flag unchanged.
- R9: Writing 1 to a status bit clears that bit only. If a set and a clear fall in the same cycle, the set wins.
- R10: irq is high exactly when some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Internal count source, one pulse per cycle high |
| extClk | input | 1 | External count source, asynchronous |
| capPin | input | 2 | Capture trigger pins, asynchronous |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| cmpOut | output | 3 | Compare output pins |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that extClk and capPin are low while reset is applied, so the synchronizers start in step with the pins. They also assume that a pin stays at each level for at least two clock cycles, so no edge is lost. The stimulus keeps every pin level for four cycles or more and holds all pins low through reset. During capture tests the counter is held still, so the expected capture value is known exactly, whatever the synchronizer delay.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int NCAP  = 2;
  localparam int NCMP  = 3;
  localparam int NFLAG = NCAP + NCMP;

  typedef enum logic [2:0] {
    MODE_KEEP   = 3'd0,
    MODE_TOGGLE = 3'd1,
    MODE_CLEAR  = 3'd2,
    MODE_SET    = 3'd3,
    MODE_PULSE  = 3'd4
  } cmpMode_e;

  typedef struct packed {
    logic             cntInc;
    logic [NCAP-1:0]  capHit;
    logic [NCMP-1:0]  frc;
    logic [NFLAG-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PS_W   = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        tick,
  input  logic                        extClk,
  input  logic [NCAP-1:0]             capPin,
  input  logic                        regWe,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic [DATA_W-1:0]           regWdata,
  output logic [DATA_W-1:0]           regRdata,
  input  logic [CNT_W-1:0]            count,
  input  logic [NCAP-1:0][CNT_W-1:0]  capVal,
  input  logic [NFLAG-1:0]            flags,
  output strobe_t                     stb,
  output logic [NCMP-1:0][CNT_W-1:0]  cmpVal,
  output logic [NCMP-1:0][2:0]        cmpMode,
  output logic                        irq
);
  localparam int CTRL_W   = 2 + 2*NCAP + 3*NCMP;
  localparam int EDGE_LSB = 2;
  localparam int MODE_LSB = 2 + 2*NCAP;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_FRC   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CNT   = ADDR_W'(5);
  localparam int CAP_BASE = 6;
  localparam int CMP_BASE = CAP_BASE + NCAP;

  logic [CTRL_W-1:0] ctrlReg;
  logic [PS_W-1:0]   presc, psCnt;
  logic [NFLAG-1:0]  ienReg;
  logic [NCAP:0]     sync1, sync2, sync3, riseDet, fallDet;
  logic              enable, clkSel, srcPulse, psWrap;

  assign enable = ctrlReg[0];
  assign clkSel = ctrlReg[1];

  // two-flop synchronizers plus one history stage; top bit is extClk
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1 <= '0; sync2 <= '0; sync3 <= '0;
    end else begin
      sync1 <= {extClk, capPin};
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end
  assign riseDet = sync2 & ~sync3;
  assign fallDet = ~sync2 & sync3;

  assign srcPulse = clkSel ? riseDet[NCAP] : tick;
  assign psWrap   = psCnt >= presc;

  always_ff @(posedge clk) begin
    if (!rstN) psCnt <= '0;
    else if (enable && srcPulse) psCnt <= psWrap ? '0 : psCnt + PS_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0; presc <= '0; ienReg <= '0; cmpVal <= '0;
    end else if (regWe) begin
      if (regAddr == A_CTRL)  ctrlReg <= regWdata[CTRL_W-1:0];
      if (regAddr == A_PRESC) presc   <= regWdata[PS_W-1:0];
      if (regAddr == A_IEN)   ienReg  <= regWdata[NFLAG-1:0];
      for (int j = 0; j < NCMP; j++)
        if (regAddr == ADDR_W'(CMP_BASE + j)) cmpVal[j] <= regWdata[CNT_W-1:0];
    end
  end

  always_comb begin
    stb.cntInc  = enable && srcPulse && psWrap;
    stb.frc     = (regWe && regAddr == A_FRC)  ? regWdata[NCMP-1:0]  : '0;
    stb.flagClr = (regWe && regAddr == A_STAT) ? regWdata[NFLAG-1:0] : '0;
  end

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    logic [1:0] edgeSel;
    assign edgeSel       = ctrlReg[EDGE_LSB + 2*i +: 2];
    assign stb.capHit[i] = (edgeSel[0] & riseDet[i]) | (edgeSel[1] & fallDet[i]);

    // R4
    cap_edge_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
      stb.capHit[i] |-> (edgeSel != 2'b00));
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_mode
    assign cmpMode[j] = ctrlReg[MODE_LSB + 3*j +: 3];
  end

  assign irq = |(flags & ienReg);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:  regRdata = DATA_W'(ctrlReg);
      A_PRESC: regRdata = DATA_W'(presc);
      A_STAT:  regRdata = DATA_W'(flags);
      A_IEN:   regRdata = DATA_W'(ienReg);
      A_CNT:   regRdata = DATA_W'(count);
      default: begin
        for (int i = 0; i < NCAP; i++)
          if (regAddr == ADDR_W'(CAP_BASE + i)) regRdata = DATA_W'(capVal[i]);
        for (int j = 0; j < NCMP; j++)
          if (regAddr == ADDR_W'(CMP_BASE + j)) regRdata = DATA_W'(cmpVal[j]);
      end
    endcase
  end
endmodule

// File: rtl/capcmp_datapath.sv
module capcmp_datapath
  import capcmp_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [NCMP-1:0][CNT_W-1:0]  cmpVal,
  input  logic [NCMP-1:0][2:0]        cmpMode,
  output logic [CNT_W-1:0]            count,
  output logic [NCAP-1:0][CNT_W-1:0]  capVal,
  output logic [NFLAG-1:0]            flags,
  output logic [NCMP-1:0]             cmpOut
);
  logic [CNT_W-1:0] nextCnt;
  logic [NCMP-1:0]  match;

  assign nextCnt = count + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else if (stb.cntInc) count <= nextCnt;
  end

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cntInc |=> (count == $past(count) + CNT_W'(1)));
  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.cntInc |=> $stable(count));

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    logic [CNT_W-1:0] capQ;
    always_ff @(posedge clk) begin
      if (!rstN) capQ <= '0;
      else if (stb.capHit[i]) capQ <= count;
    end
    assign capVal[i] = capQ;
  end

  for (genvar j = 0; j < NCMP; j++) begin : g_cmp
    logic outQ, act;
    assign match[j] = stb.cntInc && (nextCnt == cmpVal[j]);
    assign act      = match[j] | stb.frc[j];

    always_ff @(posedge clk) begin
      if (!rstN) outQ <= 1'b0;
      else begin
        case (cmpMode_e'(cmpMode[j]))
          MODE_TOGGLE: if (act) outQ <= ~outQ;
          MODE_CLEAR:  if (act) outQ <= 1'b0;
          MODE_SET:    if (act) outQ <= 1'b1;
          MODE_PULSE:  if (act) outQ <= 1'b0;
                       else if (stb.cntInc) outQ <= 1'b1;
          default:     ;
        endcase
      end
    end
    assign cmpOut[j] = outQ;

    // R5
    cmp_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      match[j] |=> flags[NCAP + j]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else flags <= {match, stb.capHit} | (flags & ~stb.flagClr);
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PS_W   = 12,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              extClk,
  input  logic [1:0]        capPin,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [2:0]        cmpOut,
  output logic              irq
);
  strobe_t                     stb;
  logic [CNT_W-1:0]            count;
  logic [NCAP-1:0][CNT_W-1:0]  capVal;
  logic [NFLAG-1:0]            flags;
  logic [NCMP-1:0][CNT_W-1:0]  cmpVal;
  logic [NCMP-1:0][2:0]        cmpMode;

  capcmp_ctrl #(.CNT_W(CNT_W), .PS_W(PS_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .extClk(extClk), .capPin(capPin),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .count(count), .capVal(capVal), .flags(flags),
    .stb(stb), .cmpVal(cmpVal), .cmpMode(cmpMode), .irq(irq)
  );

  capcmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmpVal(cmpVal), .cmpMode(cmpMode),
    .count(count), .capVal(capVal), .flags(flags), .cmpOut(cmpOut)
  );
endmodule

// File: tb/capcmp_timer_test.sv
module capcmp_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, extClk = 1'b0, regWe = 1'b0;
  logic [1:0]  capPin = 2'b00;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWdata = '0, regRdata;
  logic [2:0]  cmpOut;
  logic        irq;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  capcmp_timer uut (
    .clk(clk), .rstN(rstN), .tick(tick), .extClk(extClk), .capPin(capPin),
    .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .cmpOut(cmpOut), .irq(irq)
  );

  // presc, tick pulses, expected counter delta
  localparam int VEC[5][3] = '{'{0, 5, 5}, '{1, 6, 3}, '{3, 8, 2}, '{2, 9, 3}, '{4, 10, 2}};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a; #0.5; d = regRdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit en, input bit sel, input int e0, input int e1,
                                      input int m0, input int m1, input int m2);
    return 32'(en) | (32'(sel) << 1) | (32'(e0) << 2) | (32'(e1) << 4)
         | (32'(m0) << 6) | (32'(m1) << 9) | (32'(m2) << 12);
  endfunction

  initial begin
    #200000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0, c1;
    waitN(3); rstN = 1'b1; waitN(1);
    // R1 reset state
    rd(5, v); check("R1 count", v, 0);
    rd(2, v); check("R1 flags", v, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 cmpOut", 32'(cmpOut), 0);

    // R2 prescaler vectors
    wr(0, cw(1, 0, 0, 0, 0, 0, 0));
    for (int k = 0; k < 5; k++) begin
      wr(1, 32'(VEC[k][0]));
      rd(5, c0); ticks(VEC[k][1]); rd(5, v);
      check($sformatf("R2 vector %0d", k), v - c0, 32'(VEC[k][2]));
    end
    wr(1, 0);

    // R2 disabled hold
    wr(0, 0); rd(5, c0); ticks(4); rd(5, v);
    check("R2 hold when disabled", v, c0);

    // R3 external clock, tick held high and ignored
    wr(0, cw(1, 1, 0, 0, 0, 0, 0));
    rd(5, c0); tick = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); extClk = 1'b1; waitN(4);
      extClk = 1'b0; waitN(4);
    end
    tick = 1'b0; rd(5, v);
    check("R3 ext edges counted", v - c0, 3);

    // R4 capture: rising on ch0, counter still
    wr(0, cw(1, 0, 1, 0, 0, 0, 0));
    rd(5, c0);
    @(negedge clk); capPin[0] = 1'b1; waitN(5);
    rd(6, v); check("R4 rise capture value", v, c0);
    rd(2, v); check("R4 rise capture flag", v, 32'h1);
    wr(2, 32'h1);
    // falling mode: rising edge ignored, falling captures
    wr(0, cw(1, 0, 2, 0, 0, 0, 0));
    ticks(2); rd(5, c1);
    @(negedge clk); capPin[0] = 1'b0; waitN(5);
    rd(6, v); check("R4 fall capture value", v, c1);
    wr(2, 32'h1); ticks(1);
    @(negedge clk); capPin[0] = 1'b1; waitN(5);
    rd(2, v); check("R4 rise ignored in fall mode flag", v, 0);
    rd(6, v); check("R4 rise ignored in fall mode value", v, c1);
    // both edges on ch1
    wr(0, cw(1, 0, 0, 3, 0, 0, 0));
    rd(5, c0);
    @(negedge clk); capPin[1] = 1'b1; waitN(5);
    rd(7, v); check("R4 both mode rise", v, c0);
    ticks(3); rd(5, c1);
    @(negedge clk); capPin[1] = 1'b0; waitN(5);
    rd(7, v); check("R4 both mode fall", v, c1);
    rd(2, v); check("R4 ch1 flag", v, 32'h2);
    wr(2, 32'h3);

    // R5 R6 R7 compare: ch0 toggle, ch1 set, ch2 pulse
    wr(0, cw(1, 0, 0, 0, 1, 3, 4));
    rd(5, c0);
    wr(8, c0 + 3); wr(9, c0 + 100); wr(10, c0 + 2);
    ticks(1);
    check("R7 pulse idle high", 32'(cmpOut[2]), 1);
    check("R5 no early toggle", 32'(cmpOut[0]), 0);
    ticks(1);
    check("R7 pulse low on match", 32'(cmpOut[2]), 0);
    rd(2, v); check("R5 ch2 flag", v, 32'h10);
    ticks(1);
    check("R7 pulse returns high", 32'(cmpOut[2]), 1);
    check("R6 toggle on match", 32'(cmpOut[0]), 1);
    rd(2, v); check("R5 ch0 flag", v, 32'h14);

    // R8 force set on ch1, flag untouched
    wr(4, 32'h2);
    check("R8 forced set", 32'(cmpOut[1]), 1);
    rd(2, v); check("R8 flag unchanged", v, 32'h14);
    rd(4, v); check("R8 force reads 0", v, 0);
    // R6 clear mode via force
    wr(0, cw(1, 0, 0, 0, 2, 3, 4));
    wr(4, 32'h1);
    check("R6 clear", 32'(cmpOut[0]), 0);
    // R6 keep mode ignores force
    wr(0, cw(1, 0, 0, 0, 0, 3, 4));
    wr(4, 32'h1);
    check("R6 keep ignores force", 32'(cmpOut[0]), 0);

    // R10 irq gating, R9 write-one-to-clear
    check("R10 irq masked", 32'(irq), 0);
    wr(3, 32'h4);
    check("R10 irq enabled", 32'(irq), 1);
    wr(2, 32'h4);
    rd(2, v); check("R9 selective clear", v, 32'h10);
    check("R10 irq after clear", 32'(irq), 0);

    // R9 set wins over clear in same cycle
    rd(5, c0); wr(10, c0 + 1);
    @(negedge clk); tick = 1'b1; regWe = 1'b1; regAddr = 4'd2; regWdata = 32'h10;
    @(negedge clk); tick = 1'b0; regWe = 1'b0;
    rd(2, v); check("R9 set beats clear", v, 32'h10);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule